// File: doc/BRIEF.md
# Hashed Page Table Walker

This block finds the page-table entry that translates an effective address, given the segment descriptor that already covers it. From the descriptor word and the address it derives a virtual segment number, a page index and a compare tag. It hashes them to pick a primary group of entries in a memory-resident table, then scans that group slot by slot. If no slot matches, it scans a secondary group located by the complemented hash. A granted match updates the entry's referenced and changed flags, and the second doubleword of the entry is written back to memory only when one of those flags was newly set.

Access rights are decoded outside the walker and arrive as a three-bit input. The walker returns those rights, with write permission withdrawn while the changed flag remains clear. The first write to a clean page therefore faults instead of silently marking it dirty. Memory is reached through a single request/acknowledge port, and one walk runs at a time, framed by `busy` and a one-cycle `done`.

Top module: `hpt_walker`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy`, `done` and `mem_req` are low.
- R2: Descriptor bit 62 clear selects a 256 MB segment, with the segment number equal to descriptor bits 61:12 shifted right by 12. The segment spans 28 address bits, the page is 4 KB (descriptor bit 8 clear) or 16 MB (bit 8 set), and the page index is the address bits between the page and segment sizes, shifted down. The primary group offset is ((number XOR index) << 7) AND `tab_mask`, and entries are read at `tab_base` plus that offset.
- R3: Descriptor bit 62 set selects a 1 TB segment. The number is shifted right by 24, the segment spans 40 bits, and the hash is number XOR (number << 25) XOR index.
- R4: The compare tag is descriptor bits 63:12 ORed with ((page address >> 16) AND (2^segment_bits − 0x80)). A first doubleword matches when bit 0 (valid) is 1, bit 1 (secondary) equals the pass (0 primary, 1 secondary) and bits 63:7 equal the tag.
- R5: Slots 0 to 7 of a group are scanned in order, 16 bytes apart. Each slot takes a read at +0 and then a read at +8, and the first matching slot ends the walk.
- R6: After the primary group misses, the secondary group at ((~hash) << 7) AND `tab_mask` is scanned. Missing both ends with `found` low and `rights_out` zero after 32 reads.
- R7: On a match, bit 8 (referenced) of the returned second doubleword is set.
- R8: Bit 7 (changed) is set when it was clear and the access is a write with `rights_in[1]` (write) set. `rights_in` bit 0 is read, bit 1 write, bit 2 execute.
- R9: On a match, `rights_out` equals `rights_in`, except that bit 1 is cleared when bit 7 of the returned doubleword is still clear.
- R10: The updated second doubleword is written to slot address +8 only when bit 7 or bit 8 was newly set; otherwise the walk issues no write.
- R11: `mem_req` is held, with address, write flag and data stable, until `mem_ack`. `busy` is high from the cycle after `start` until `done`, and `done` lasts one cycle with `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a walk (taken when idle) |
| seg_word | input | 64 | Segment descriptor word |
| eff_addr | input | 64 | Effective address to translate |
| tab_base | input | 64 | Byte address of the page table |
| tab_mask | input | 64 | Mask applied to group offsets |
| acc_write | input | 1 | Access is a store |
| rights_in | input | 3 | Decoded rights {exec, write, read} |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | A matching entry was located |
| hit_addr | output | 64 | Byte address of the matching slot |
| hit_dw0 | output | 64 | First doubleword of the match |
| hit_dw1 | output | 64 | Updated second doubleword |
| rights_out | output | 3 | Rights after the first-write rule |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Request byte address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Request accepted / read data valid |
| mem_rdata | input | 64 | Read data |

## Verification
A wrong slot counter or pass flag shows up within one slot as a read at an unexpected address and as a read count that differs from the reference scan at `done`. A corrupted hash lands the walk in the wrong group, which appears as a miss or as a wrong `hit_addr`. A flag-update fault is visible at `done` on `hit_dw1` and `rights_out`, and in the stored table word immediately after the write-back, or as a spurious or missing write.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
   localparam int WORD_W = 64;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD0,
      ST_RD1,
      ST_EVAL,
      ST_WB,
      ST_FIN
   } walk_st_t;

   // rights vector layout
   localparam int RT_READ  = 0;
   localparam int RT_WRITE = 1;
   localparam int RT_EXEC  = 2;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash import hpt_pkg::*; #(
   parameter int SIZE_BIT   = 62,
   parameter int LARGE_BIT  = 8,
   parameter int VSID_LSB   = 12,
   parameter int VSID_MSB   = 61,
   parameter int SH_SMALL   = 12,
   parameter int SH_BIG     = 24,
   parameter int SEG_SMALL  = 28,
   parameter int SEG_BIG    = 40,
   parameter int PG_BASE    = 12,
   parameter int PG_HUGE    = 24,
   parameter int TAG_SHIFT  = 16,
   parameter int GRP_SHIFT  = 7,
   parameter bit SUPPORT_1T = 1'b1
) (
   input  logic [WORD_W-1:0] seg_word,
   input  logic [WORD_W-1:0] ea,
   input  logic [WORD_W-1:0] tab_mask,
   output logic [WORD_W-1:0] pri_off,
   output logic [WORD_W-1:0] sec_off,
   output logic [WORD_W-1:0] tag
);
   localparam logic [WORD_W-1:0] TAG_MASK  = ~((64'd1 << VSID_LSB) - 64'd1);
   localparam logic [WORD_W-1:0] VSID_MASK = ((64'd1 << (VSID_MSB + 1)) - 64'd1) & TAG_MASK;
   localparam logic [WORD_W-1:0] ABBR_LOW  = 64'd1 << GRP_SHIFT;

   logic                is_1t;
   logic                is_large;
   logic [5:0]          vsh, ssh, psh;
   logic [WORD_W-1:0]   vsid, seg_span, pg_span, page_addr, pidx, hash;

   assign is_large  = seg_word[LARGE_BIT];
   assign vsh       = is_1t ? 6'(SH_BIG)  : 6'(SH_SMALL);
   assign ssh       = is_1t ? 6'(SEG_BIG) : 6'(SEG_SMALL);
   assign psh       = is_large ? 6'(PG_HUGE) : 6'(PG_BASE);
   assign vsid      = (seg_word & VSID_MASK) >> vsh;
   assign seg_span  = 64'd1 << ssh;
   assign pg_span   = 64'd1 << psh;
   assign page_addr = ea & (seg_span - pg_span);
   assign pidx      = page_addr >> psh;

   generate
      if (SUPPORT_1T) begin : g_both_sizes
         assign is_1t = seg_word[SIZE_BIT];
         assign hash  = is_1t ? (vsid ^ (vsid << 25) ^ pidx) : (vsid ^ pidx);
      end else begin : g_small_only
         assign is_1t = 1'b0;
         assign hash  = vsid ^ pidx;
      end
   endgenerate

   assign tag     = (seg_word & TAG_MASK) | ((page_addr >> TAG_SHIFT) & (seg_span - ABBR_LOW));
   assign pri_off = (hash << GRP_SHIFT) & tab_mask;
   assign sec_off = ((~hash) << GRP_SHIFT) & tab_mask;
endmodule

// File: rtl/hpt_match.sv
module hpt_match import hpt_pkg::*; #(
   parameter int VALID_BIT = 0,
   parameter int SEC_BIT   = 1,
   parameter int CMP_LSB   = 7
) (
   input  logic [WORD_W-1:0] dw0,
   input  logic [WORD_W-1:0] tag,
   input  logic              pass,
   output logic              hit
);
   localparam logic [WORD_W-1:0] CMP_MASK = ~((64'd1 << CMP_LSB) - 64'd1);

   assign hit = dw0[VALID_BIT] && (dw0[SEC_BIT] == pass)
              && (((dw0 ^ tag) & CMP_MASK) == '0);
endmodule

// File: rtl/hpt_refchg.sv
module hpt_refchg import hpt_pkg::*; #(
   parameter int REF_BIT = 8,
   parameter int CHG_BIT = 7
) (
   input  logic [WORD_W-1:0] dw1_in,
   input  logic              acc_write,
   input  logic [2:0]        rights_in,
   output logic [WORD_W-1:0] dw1_out,
   output logic [2:0]        rights_out,
   output logic              dirty
);
   logic wr_granted;

   assign wr_granted = acc_write && rights_in[RT_WRITE];

   always_comb begin
      dw1_out    = dw1_in;
      rights_out = rights_in;
      dw1_out[REF_BIT] = 1'b1;
      if (!dw1_in[CHG_BIT]) begin
         if (wr_granted) dw1_out[CHG_BIT] = 1'b1;
         else            rights_out[RT_WRITE] = 1'b0;
      end
      dirty = (dw1_out != dw1_in);
   end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker import hpt_pkg::*; #(
   parameter int ENTRIES     = 8,
   parameter int ENTRY_BYTES = 16,
   parameter int SIZE_BIT    = 62,
   parameter int LARGE_BIT   = 8,
   parameter int VALID_BIT   = 0,
   parameter int SEC_BIT     = 1,
   parameter int REF_BIT     = 8,
   parameter int CHG_BIT     = 7,
   parameter bit SUPPORT_1T  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [63:0]       seg_word,
   input  logic [63:0]       eff_addr,
   input  logic [63:0]       tab_base,
   input  logic [63:0]       tab_mask,
   input  logic              acc_write,
   input  logic [2:0]        rights_in,
   output logic              busy,
   output logic              done,
   output logic              found,
   output logic [63:0]       hit_addr,
   output logic [63:0]       hit_dw0,
   output logic [63:0]       hit_dw1,
   output logic [2:0]        rights_out,
   output logic              mem_req,
   output logic              mem_we,
   output logic [63:0]       mem_addr,
   output logic [63:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [63:0]       mem_rdata
);
   localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam int ENT_SHIFT = $clog2(ENTRY_BYTES);
   localparam int GRP_SHIFT = $clog2(ENTRIES * ENTRY_BYTES);
   localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(ENTRIES - 1);
   localparam logic [WORD_W-1:0] HALF_OFF = WORD_W'(ENTRY_BYTES / 2);

   initial begin
      e_entries_pow2 : assert (ENTRIES >= 2 && (ENTRIES & (ENTRIES - 1)) == 0);
      e_entry_bytes  : assert (ENTRY_BYTES == 16);
      e_flag_bits    : assert (REF_BIT != CHG_BIT && VALID_BIT != SEC_BIT);
   end

   walk_st_t            st;
   logic                pass_q, wr_q, found_q, hit;
   logic [IDX_W-1:0]    idx_q;
   logic [WORD_W-1:0]   seg_q, ea_q, base_q, mask_q, dw0_q, dw1_q, hit_addr_q;
   logic [2:0]          rights_q, rights_o_q, rights_nx;
   logic [WORD_W-1:0]   pri_off, sec_off, tag, ent_addr, dw1_nx;
   logic                dirty;

   hpt_hash #(
      .SIZE_BIT(SIZE_BIT), .LARGE_BIT(LARGE_BIT), .GRP_SHIFT(GRP_SHIFT),
      .SUPPORT_1T(SUPPORT_1T)
   ) u_hash (
      .seg_word(seg_q), .ea(ea_q), .tab_mask(mask_q),
      .pri_off(pri_off), .sec_off(sec_off), .tag(tag)
   );

   hpt_match #(.VALID_BIT(VALID_BIT), .SEC_BIT(SEC_BIT), .CMP_LSB(GRP_SHIFT)) u_match (
      .dw0(dw0_q), .tag(tag), .pass(pass_q), .hit(hit)
   );

   hpt_refchg #(.REF_BIT(REF_BIT), .CHG_BIT(CHG_BIT)) u_rc (
      .dw1_in(dw1_q), .acc_write(wr_q), .rights_in(rights_q),
      .dw1_out(dw1_nx), .rights_out(rights_nx), .dirty(dirty)
   );

   assign ent_addr = base_q + (pass_q ? sec_off : pri_off)
                   + ({{(WORD_W-IDX_W){1'b0}}, idx_q} << ENT_SHIFT);

   assign mem_req   = (st == ST_RD0) || (st == ST_RD1) || (st == ST_WB);
   assign mem_we    = (st == ST_WB);
   assign mem_addr  = ent_addr + (((st == ST_RD1) || (st == ST_WB)) ? HALF_OFF : '0);
   assign mem_wdata = dw1_q;

   assign busy       = (st != ST_IDLE) && (st != ST_FIN);
   assign done       = (st == ST_FIN);
   assign found      = found_q;
   assign hit_addr   = hit_addr_q;
   assign hit_dw0    = dw0_q;
   assign hit_dw1    = dw1_q;
   assign rights_out = rights_o_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         st         <= ST_IDLE;
         pass_q     <= 1'b0;
         idx_q      <= '0;
         wr_q       <= 1'b0;
         found_q    <= 1'b0;
         seg_q      <= '0;
         ea_q       <= '0;
         base_q     <= '0;
         mask_q     <= '0;
         dw0_q      <= '0;
         dw1_q      <= '0;
         hit_addr_q <= '0;
         rights_q   <= '0;
         rights_o_q <= '0;
      end else begin
         unique case (st)
            ST_IDLE: if (start) begin
               seg_q    <= seg_word;
               ea_q     <= eff_addr;
               base_q   <= tab_base;
               mask_q   <= tab_mask;
               wr_q     <= acc_write;
               rights_q <= rights_in;
               pass_q   <= 1'b0;
               idx_q    <= '0;
               found_q  <= 1'b0;
               st       <= ST_RD0;
            end
            ST_RD0: if (mem_ack) begin
               dw0_q <= mem_rdata;
               st    <= ST_RD1;
            end
            ST_RD1: if (mem_ack) begin
               dw1_q <= mem_rdata;
               st    <= ST_EVAL;
            end
            ST_EVAL: begin
               if (hit) begin
                  dw1_q      <= dw1_nx;
                  rights_o_q <= rights_nx;
                  found_q    <= 1'b1;
                  hit_addr_q <= ent_addr;
                  st         <= dirty ? ST_WB : ST_FIN;
               end else if (idx_q == LAST_IDX) begin
                  if (!pass_q) begin
                     pass_q <= 1'b1;
                     idx_q  <= '0;
                     st     <= ST_RD0;
                  end else begin
                     rights_o_q <= '0;
                     st         <= ST_FIN;
                  end
               end else begin
                  idx_q <= idx_q + 1'b1;
                  st    <= ST_RD0;
               end
            end
            ST_WB:   if (mem_ack) st <= ST_FIN;
            ST_FIN:  st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R11: request held steady until accepted
   a_r11_req_hold : assert property (@(posedge clk) disable iff (rst)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
   // R11: completion is a single cycle with busy low
   a_r11_done_pulse : assert property (@(posedge clk) disable iff (rst)
      done |-> !busy ##1 !done);
   // R10: the only write targets the second doubleword of a slot
   a_r10_wb_half : assert property (@(posedge clk) disable iff (rst)
      mem_req && mem_we |-> mem_addr[ENT_SHIFT-1:0] == ENT_SHIFT'(ENTRY_BYTES / 2));
   // R7: a returned match always carries the referenced flag
   a_r7_ref_set : assert property (@(posedge clk) disable iff (rst)
      done && found |-> hit_dw1[REF_BIT]);
   // R9: a clean page never hands out write permission
   a_r9_first_write : assert property (@(posedge clk) disable iff (rst)
      done && found && !hit_dw1[CHG_BIT] |-> !rights_out[RT_WRITE]);
   // R6: a miss returns no rights
   a_r6_miss_rights : assert property (@(posedge clk) disable iff (rst)
      done && !found |-> rights_out == 3'b000);
endmodule

// File: tb/sim_hpt_walker.sv
module sim_hpt_walker;
   localparam int CLK_P = 10;
   localparam logic [63:0] TBASE = 64'h0000_0001_0000_0000;
   localparam logic [63:0] TMASK = 64'h0000_0000_003F_FF80;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [63:0] seg_word = '0, eff_addr = '0, tab_base = TBASE, tab_mask = TMASK;
   logic        acc_write = 1'b0;
   logic [2:0]  rights_in = '0;
   logic        busy, done, found, mem_req, mem_we;
   logic [63:0] hit_addr, hit_dw0, hit_dw1, mem_addr, mem_wdata;
   logic [2:0]  rights_out;
   logic        mem_ack;
   logic [63:0] mem_rdata;

   int n_run = 0, n_fail = 0, rd_cnt = 0, wr_cnt = 0;
   logic [63:0] mem [logic [63:0]];

   always #(CLK_P/2) clk = ~clk;

   hpt_walker u0 (
      .clk(clk), .rst(rst), .start(start), .seg_word(seg_word), .eff_addr(eff_addr),
      .tab_base(tab_base), .tab_mask(tab_mask), .acc_write(acc_write), .rights_in(rights_in),
      .busy(busy), .done(done), .found(found), .hit_addr(hit_addr), .hit_dw0(hit_dw0),
      .hit_dw1(hit_dw1), .rights_out(rights_out), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   function automatic logic [63:0] peek(input logic [63:0] a);
      return mem.exists(a) ? mem[a] : 64'd0;
   endfunction

   // memory: one idle cycle per request, then acknowledge
   always @(posedge clk) begin
      if (rst) begin
         mem_ack   <= 1'b0;
         mem_rdata <= '0;
      end else if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            wr_cnt++;
         end else begin
            mem_rdata <= peek(mem_addr);
            rd_cnt++;
         end
      end else begin
         mem_ack <= 1'b0;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // reference: segment geometry, hash and tag from the requirement text
   function automatic logic [63:0] ref_group(input logic [63:0] seg, input logic [63:0] ea, input bit second);
      bit big = seg[62];
      int sb = big ? 40 : 28;
      int pb = seg[8] ? 24 : 12;
      logic [63:0] num = (seg & 64'h3FFF_FFFF_FFFF_F000) >> (big ? 24 : 12);
      logic [63:0] pa  = ea & ((64'd1 << sb) - (64'd1 << pb));
      logic [63:0] h   = big ? (num ^ (num << 25) ^ (pa >> pb)) : (num ^ (pa >> pb));
      if (second) h = ~h;
      return TBASE + ((h << 7) & TMASK);
   endfunction

   function automatic logic [63:0] ref_tag(input logic [63:0] seg, input logic [63:0] ea);
      int sb = seg[62] ? 40 : 28;
      int pb = seg[8] ? 24 : 12;
      logic [63:0] pa = ea & ((64'd1 << sb) - (64'd1 << pb));
      return (seg & 64'hFFFF_FFFF_FFFF_F000) | ((pa >> 16) & ((64'd1 << sb) - 64'h80));
   endfunction

   task automatic put(input logic [63:0] seg, input logic [63:0] ea, input bit second, input int k,
                      input logic [63:0] d0, input logic [63:0] d1);
      logic [63:0] a = ref_group(seg, ea, second) + 64'(k * 16);
      mem[a]     = d0;
      mem[a + 8] = d1;
   endtask

   task automatic walk(input logic [63:0] seg, input logic [63:0] ea, input logic wr,
                       input logic [2:0] rt, input string req, input int hand_reads);
      logic [63:0] tg = ref_tag(seg, ea);
      bit          ef = 1'b0;
      int          er = 0;
      logic [63:0] ea_hit = '0, e0 = '0, e1 = '0, n1 = '0;
      logic [2:0]  ert = 3'b000;
      int          r0, w0, cyc;
      for (int p = 0; p < 2; p++) begin
         for (int k = 0; k < 8; k++) begin
            if (!ef) begin
               logic [63:0] a = ref_group(seg, ea, p[0]) + 64'(k * 16);
               logic [63:0] d0 = peek(a);
               logic [63:0] d1 = peek(a + 8);
               er += 2;
               if (d0[0] && d0[1] == p[0] && ((d0 ^ tg) & ~64'h7F) == 64'd0) begin
                  ef = 1'b1; ea_hit = a; e0 = d0; e1 = d1;
               end
            end
         end
      end
      if (ef) begin
         ert = rt;
         n1 = e1 | 64'h100;
         if (!e1[7]) begin
            if (wr && rt[1]) n1 = n1 | 64'h80;
            else ert[1] = 1'b0;
         end
      end
      r0 = rd_cnt; w0 = wr_cnt;
      @(negedge clk);
      seg_word = seg; eff_addr = ea; acc_write = wr; rights_in = rt; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (!done && cyc < 3000) begin
         chk(busy === 1'b1, "R11 busy during walk", 64'(busy), 64'd1);
         @(negedge clk);
         cyc++;
      end
      chk(done === 1'b1, "R11 walk completes", 64'(done), 64'd1);
      chk(busy === 1'b0, "R11 busy low with done", 64'(busy), 64'd0);
      chk(found === ef, {req, " found"}, 64'(found), 64'(ef));
      chk(rights_out === ert, "R9 rights", 64'(rights_out), 64'(ert));
      chk(rd_cnt - r0 == er, {req, " R5 read count"}, 64'(rd_cnt - r0), 64'(er));
      if (hand_reads >= 0)
         chk(rd_cnt - r0 == hand_reads, {req, " read count by hand"}, 64'(rd_cnt - r0), 64'(hand_reads));
      chk(wr_cnt - w0 == ((ef && n1 != e1) ? 1 : 0), "R10 write count",
          64'(wr_cnt - w0), 64'((ef && n1 != e1) ? 1 : 0));
      if (ef) begin
         chk(hit_addr === ea_hit, {req, " hit address"}, hit_addr, ea_hit);
         chk(hit_dw0 === e0, "R4 matched first doubleword", hit_dw0, e0);
         chk(hit_dw1 === n1, "R7 R8 updated second doubleword", hit_dw1, n1);
         chk(peek(ea_hit + 8) === n1, "R10 table word after walk", peek(ea_hit + 8), n1);
      end
      @(negedge clk);
      chk(done === 1'b0, "R11 done single cycle", 64'(done), 64'd0);
   endtask

   initial begin
      #(CLK_P * 150000);
      n_fail++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] s1, e1, t1, s2, e2, t2;
      repeat (3) @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0, "R1 in reset",
          {61'd0, busy, done, mem_req}, 64'd0);
      rst = 1'b0;
      @(negedge clk);
      chk(busy === 1'b0, "R1 busy after reset", 64'(busy), 64'd0);
      chk(mem_req === 1'b0, "R1 no request after reset", 64'(mem_req), 64'd0);

      s1 = 64'h0000_0000_1234_5000;
      e1 = 64'h0000_0000_0ABC_D123;
      t1 = ref_tag(s1, e1);

      // R2: read, clean page, slot 0 primary
      mem.delete();
      put(s1, e1, 1'b0, 0, t1 | 64'h1, 64'h0000_0000_5555_0000);
      walk(s1, e1, 1'b0, 3'b011, "R2", 2);

      // R4: invalid and mismatched slots skipped; granted write marks changed (R8)
      mem.delete();
      put(s1, e1, 1'b0, 0, t1, 64'h0);
      put(s1, e1, 1'b0, 1, t1 ^ 64'h0000_0100_0000_0001, 64'h0);
      put(s1, e1, 1'b0, 3, t1 | 64'h1, 64'h0000_0000_1234_0000);
      walk(s1, e1, 1'b1, 3'b011, "R4", 8);

      // R9: write without write right leaves changed clear
      mem.delete();
      put(s1, e1, 1'b0, 3, t1 | 64'h1, 64'h0000_0000_1234_0000);
      walk(s1, e1, 1'b1, 3'b001, "R9", 8);

      // R10: flags already set, no write-back
      mem.delete();
      put(s1, e1, 1'b0, 0, t1 | 64'h1, 64'h0000_0000_0000_9180);
      walk(s1, e1, 1'b1, 3'b111, "R10", 2);

      // R6: secondary-flagged entry ignored on primary, found in secondary slot 4
      mem.delete();
      put(s1, e1, 1'b0, 0, t1 | 64'h3, 64'h0);
      put(s1, e1, 1'b1, 4, t1 | 64'h3, 64'h0);
      walk(s1, e1, 1'b0, 3'b111, "R6", 26);

      // R6: both groups miss
      mem.delete();
      put(s1, e1, 1'b1, 2, t1 | 64'h1, 64'h0);
      walk(s1, e1, 1'b0, 3'b111, "R6", 32);

      // R3: 1 TB segment, 16 MB page, two matches, first wins (R5)
      s2 = 64'h4000_0003_ABCD_0100;
      e2 = 64'h0000_00AB_CD05_6000;
      t2 = ref_tag(s2, e2);
      mem.delete();
      put(s2, e2, 1'b0, 2, t2 | 64'h1, 64'h0000_0000_0000_0080);
      put(s2, e2, 1'b0, 5, t2 | 64'h1, 64'h0);
      walk(s2, e2, 1'b1, 3'b011, "R3", 6);

      // R3: same segment, read of a clean page in slot 7
      mem.delete();
      put(s2, e2, 1'b0, 7, t2 | 64'h1, 64'h0000_0000_7700_0000);
      walk(s2, e2, 1'b0, 3'b111, "R3", 16);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule